// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a 16-bit virtual address onto a physical address through a small segment table held in flip-flops. The top bits of the virtual address pick one table entry. Each entry holds a base, a limit and a valid flag. The remaining bits form an offset inside the segment.

The offset is added to the entry's base. The same offset is compared against the entry's limit. A request that hits an unloaded entry, or that runs past the end of its segment, returns a fault code and no usable address.

Software fills the table through a synchronous write port. Translation requests enter with a valid strobe. Each result comes back one clock later on a registered response. No memory is accessed on the way, because the whole lookup is a register read, an add and a compare.

Top module: `seg_xlate`

## Requirements
- R1: The virtual address is split as follows: bits 15:14 are the segment number (0 to 3), and bits 13:0 are the offset.
- R2: When no fault occurs, resp_paddr equals the selected entry's base plus the zero-extended offset, taken modulo 2^16.
- R3: An offset greater than or equal to the entry's limit is a bounds fault. It is reported as resp_fault = 2'b10. A limit of 0x0800 therefore admits offsets 0x000 through 0x7FF.
- R4: A request to an entry whose valid flag is clear is reported as resp_fault = 2'b01. This code wins over a bounds fault. A successful translation reports 2'b00, and the code 2'b11 never appears.
- R5: Whenever resp_fault is non-zero, resp_paddr is zero.
- R6: resp_valid is high in exactly those cycles that follow a cycle in which req_valid was high, and it is low otherwise.
- R7: On a clock edge with wr_en high, entry wr_idx takes wr_base, wr_limit and wr_valid. Later requests to that entry use the new values.
- R8: If a write and a request address the same entry in the same cycle, the response is computed from the entry as it was before the write.
- R9: Synchronous reset clears every table entry to invalid. It also drives resp_valid, resp_paddr and resp_fault to zero. After reset, every request faults with 2'b01 until its entry is written.
- R10: In a cycle without a request, resp_paddr and resp_fault keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 2 | Entry to write |
| wr_base | input | 16 | Base value to store |
| wr_limit | input | 15 | Segment length to store (0 to 0x4000) |
| wr_valid | input | 1 | Valid flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| resp_valid | output | 1 | Response strobe, one clock after the request |
| resp_paddr | output | 16 | Translated physical address, zero on a fault |
| resp_fault | output | 2 | 00 no fault, 01 invalid segment, 10 out of bounds |

## Verification
The bench builds the block with its default widths: a 16-bit virtual address, a 2-bit segment field and a 16-bit physical address. With only four entries, random traffic hits every entry many times. Mixed random writes to the entries also leave each one both valid and invalid at different points in the run.

The 14-bit offset and the 15-bit limit let directed cases reach several boundaries:
- the offset just below the limit and exactly at it;
- a zero limit;
- a full 0x4000 limit;
- a base near the top of the address space, where the addition wraps around.

Same-cycle write and lookup collisions are driven both directly and at random.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int DEF_VA_W  = 16;
    localparam int DEF_SEG_W = 2;
    localparam int DEF_PA_W  = 16;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_INVALID = 2'b01,
        FLT_BOUNDS  = 2'b10
    } fault_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W = 2,
    parameter int PA_W  = 16,
    parameter int LIM_W = 15,
    localparam int NSEG = 1 << SEG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LIM_W-1:0] wr_limit,
    input  logic             wr_valid,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [LIM_W-1:0] rd_limit,
    output logic             rd_valid
);

    logic [PA_W-1:0]  base_q  [NSEG];
    logic [LIM_W-1:0] limit_q [NSEG];
    logic [NSEG-1:0]  valid_q;

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == SEG_W'(g))) begin
                base_q[g]  <= wr_base;
                limit_q[g] <= wr_limit;
                valid_q[g] <= wr_valid;
            end
        end
    end

    // The read is combinational from the current flops, so a write in the same cycle is not seen.
    assign rd_base  = base_q[rd_idx];
    assign rd_limit = limit_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W = 14,
    parameter int PA_W  = 16,
    localparam int LIM_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [PA_W-1:0]  base,
    input  logic [LIM_W-1:0] limit,
    input  logic             valid,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr
);

    logic            over;
    logic [PA_W-1:0] sum;

    assign over = {1'b0, offset} >= limit;
    assign sum  = base + PA_W'(offset);

    always_comb begin
        if (!valid) begin
            fault = FLT_INVALID;
            paddr = '0;
        end else if (over) begin
            fault = FLT_BOUNDS;
            paddr = '0;
        end else begin
            fault = FLT_NONE;
            paddr = sum;
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = DEF_VA_W,
    parameter int SEG_W = DEF_SEG_W,
    parameter int PA_W  = DEF_PA_W,
    localparam int OFF_W = VA_W - SEG_W,
    localparam int LIM_W = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LIM_W-1:0] wr_limit,
    input  logic             wr_valid,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [1:0]       resp_fault
);

    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic [PA_W-1:0]  ent_base;
    logic [LIM_W-1:0] ent_limit;
    logic             ent_valid;
    fault_e           nxt_fault;
    logic [PA_W-1:0]  nxt_paddr;

    assign seg = req_vaddr[VA_W-1 -: SEG_W];
    assign off = req_vaddr[OFF_W-1:0];

    seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_base  (wr_base),
        .wr_limit (wr_limit),
        .wr_valid (wr_valid),
        .rd_idx   (seg),
        .rd_base  (ent_base),
        .rd_limit (ent_limit),
        .rd_valid (ent_valid)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .offset (off),
        .base   (ent_base),
        .limit  (ent_limit),
        .valid  (ent_valid),
        .fault  (nxt_fault),
        .paddr  (nxt_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_fault <= FLT_NONE;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                resp_paddr <= nxt_paddr;
                resp_fault <= nxt_fault;
            end
        end
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int VA_W  = 16,
    parameter int SEG_W = 2,
    parameter int PA_W  = 16,
    localparam int OFF_W = VA_W - SEG_W,
    localparam int LIM_W = OFF_W + 1,
    localparam int NSEG  = 1 << SEG_W
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [SEG_W-1:0] wr_idx,
    input logic [LIM_W-1:0] wr_limit,
    input logic             wr_valid,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             resp_valid,
    input logic [PA_W-1:0]  resp_paddr,
    input logic [1:0]       resp_fault
);

    // Shadow copy of the table, kept from the write port alone.
    logic [NSEG-1:0]  sh_valid;
    logic [LIM_W-1:0] sh_limit [NSEG];
    logic [SEG_W-1:0] q_seg;
    logic [OFF_W-1:0] q_off;

    assign q_seg = req_vaddr[VA_W-1 -: SEG_W];
    assign q_off = req_vaddr[OFF_W-1:0];

    for (genvar g = 0; g < NSEG; g++) begin : g_sh
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_valid[g] <= 1'b0;
                sh_limit[g] <= '0;
            end else if (wr_en && wr_idx == SEG_W'(g)) begin
                sh_valid[g] <= wr_valid;
                sh_limit[g] <= wr_limit;
            end
        end
    end

    a_r6_resp_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    a_r6_no_resp_without_req: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        resp_fault != 2'b00 |-> resp_paddr == '0);

    a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
        resp_fault != 2'b11);

    a_r4_invalid_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sh_valid[q_seg]) |=> resp_fault == 2'b01);

    a_r3_bounds_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sh_valid[q_seg] && {1'b0, q_off} >= sh_limit[q_seg])
        |=> resp_fault == 2'b10);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(resp_paddr) && $stable(resp_fault)));

endmodule

bind seg_xlate seg_xlate_chk #(.VA_W(VA_W), .SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_limit   (wr_limit),
    .wr_valid   (wr_valid),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .resp_valid (resp_valid),
    .resp_paddr (resp_paddr),
    .resp_fault (resp_fault)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [15:0] wr_base = '0;
    logic [14:0] wr_limit = '0;
    logic        wr_valid = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        resp_valid;
    logic [15:0] resp_paddr;
    logic [1:0]  resp_fault;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_base [4];
    logic [14:0] m_lim  [4];
    logic        m_val  [4];

    always #5 clk = ~clk;

    seg_xlate dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_valid(wr_valid), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference result from the requirements (R1..R5).
    function automatic void ref_xl(input logic [15:0] va, output logic [1:0] f, output logic [15:0] p);
        logic [1:0]  s;
        logic [13:0] o;
        s = va[15:14];
        o = va[13:0];
        if (!m_val[s]) begin
            f = 2'b01; p = '0;
        end else if ({1'b0, o} >= m_lim[s]) begin
            f = 2'b10; p = '0;
        end else begin
            f = 2'b00; p = m_base[s] + 16'(o);
        end
    endfunction

    task automatic wr(input logic [1:0] i, input logic [15:0] b, input logic [14:0] l, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_base = b; wr_limit = l; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_base[i] = b; m_lim[i] = l; m_val[i] = v;
    endtask

    task automatic xl(input logic [15:0] va, input string tag);
        logic [1:0]  ef;
        logic [15:0] ep;
        ref_xl(va, ef, ep);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R6 resp_valid"}, 32'(resp_valid), 32'd1);
        chk({tag, " fault"}, 32'(resp_fault), 32'(ef));
        chk({tag, " paddr"}, 32'(resp_paddr), 32'(ep));
    endtask

    // Write and request in one cycle: R8 expects the pre-write entry.
    task automatic wr_xl(input logic [1:0] i, input logic [15:0] b, input logic [14:0] l,
                         input logic v, input logic [15:0] va, input string tag);
        logic [1:0]  ef;
        logic [15:0] ep;
        ref_xl(va, ef, ep);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_base = b; wr_limit = l; wr_valid = v;
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        m_base[i] = b; m_lim[i] = l; m_val[i] = v;
        chk({tag, " fault"}, 32'(resp_fault), 32'(ef));
        chk({tag, " paddr"}, 32'(resp_paddr), 32'(ep));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] hold_p;
        logic [1:0]  hold_f;
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_val[i] = 1'b0;
        end
        void'($urandom(32'd20250));
        repeat (3) @(negedge clk);
        // R9: outputs while reset is held
        chk("R9 reset resp_valid", 32'(resp_valid), 32'd0);
        chk("R9 reset paddr", 32'(resp_paddr), 32'd0);
        chk("R9 reset fault", 32'(resp_fault), 32'd0);
        rst = 1'b0;

        // R9: unloaded table faults as invalid
        xl(16'h0240, "R9 empty seg0");
        xl(16'hC123, "R9 empty seg3");

        // R7: load the example table
        wr(2'd0, 16'h4000, 15'h0800, 1'b1);
        wr(2'd1, 16'h4800, 15'h1400, 1'b1);
        wr(2'd2, 16'hF000, 15'h1000, 1'b1);
        wr(2'd3, 16'h0000, 15'h3000, 1'b1);

        // R1 R2: directed translations
        xl(16'h0240, "R2 code 0x0240");
        chk("R2 0x0240->0x4240", 32'(resp_paddr), 32'h4240);
        xl(16'h4050, "R1 data 0x4050");
        chk("R1 0x4050->0x4850", 32'(resp_paddr), 32'h4850);

        // R3: strict bound
        xl(16'h07FF, "R3 last in range");
        xl(16'h0800, "R3 at limit");
        chk("R3 code 10", 32'(resp_fault), 32'h2);
        xl(16'h3FFF, "R3 far out");

        // R2: wraparound at top of space
        wr(2'd2, 16'hF000, 15'h4000, 1'b1);
        xl(16'hBFFF, "R2 wrap");
        chk("R2 wrap value", 32'(resp_paddr), 32'h2FFF);

        // R3: zero limit faults everything
        wr(2'd3, 16'h1234, 15'h0000, 1'b1);
        xl(16'hC000, "R3 zero limit");

        // R4: invalid wins over bounds
        wr(2'd1, 16'h4800, 15'h0010, 1'b0);
        xl(16'h7FFF, "R4 invalid priority");
        chk("R4 code 01", 32'(resp_fault), 32'h1);

        // R10: hold without request
        xl(16'h0100, "R10 setup");
        hold_p = resp_paddr;
        hold_f = resp_fault;
        @(negedge clk);
        @(negedge clk);
        chk("R10 hold paddr", 32'(resp_paddr), 32'(hold_p));
        chk("R10 hold fault", 32'(resp_fault), 32'(hold_f));
        chk("R6 idle resp_valid", 32'(resp_valid), 32'd0);

        // R8: same-cycle write and lookup
        wr_xl(2'd0, 16'h9000, 15'h0100, 1'b0, 16'h0020, "R8 old entry");
        chk("R8 old base used", 32'(resp_paddr), 32'h4020);
        xl(16'h0020, "R7 new entry applied");

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [1:0]  ri;
            logic [15:0] rb;
            logic [14:0] rl;
            logic        rv;
            logic [15:0] va;
            op = $urandom_range(0, 3);
            ri = 2'($urandom_range(0, 3));
            rb = 16'($urandom);
            rl = 15'($urandom_range(0, 16'h4000));
            rv = ($urandom_range(0, 3) != 0);
            va = 16'($urandom);
            if (op == 0) wr(ri, rb, rl, rv);
            else if (op == 1) wr_xl(ri, rb, rl, rv, {ri, va[13:0]}, "R8 random");
            else xl(va, "R2 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule